// File: doc/BRIEF.md
# Asynchronous Serial Adapter with Two-Address Host Port

The adapter moves bytes between a host and one asynchronous serial line. The host sees two addresses, picked by a register-select input. At the first address a write sets the control word and a read returns the status byte. At the second address a write queues a transmit byte and a read takes the received byte. Line timing comes from an external bit-clock enable. The adapter divides it by 64, 16 or 1 and sends or receives characters in one of eight fixed data, parity and stop combinations. The least significant data bit goes first, after a low start bit.

Each direction holds at most two characters: one in a holding register and one in its shift register. The control word also drives an active-low request-to-send pin, can hold the line in a continuous break, and enables the receive and transmit interrupt sources. The carrier-detect and clear-to-send inputs are only reported as levels in the status byte. After reset the adapter sits in master reset until the host writes a control word with another rate code.

Top module: `sa_top`

## Requirements
- R1: After reset, and whenever control bits 1:0 equal 3, the adapter is in master reset. The line output sits at mark (1) and irq is 0. Once a clock has passed, the status byte shows only bit 1 plus the two input-level bits, and a byte waiting in the receive holding register is dropped.
- R2: Control bits 1:0 set the bit time to 64 (code 0), 16 (code 1) or 1 (code 2) pulses of bclk_en. The bench applies one pulse every two clocks, so a bit lasts 128, 32 or 2 clocks.
- R3: Control bits 4:2 pick the format. Code 0 is 7 data bits, even parity, 2 stop bits. The other codes are: 1 = 7 odd 2, 2 = 7 even 1, 3 = 7 odd 1, 4 = 8 none 2, 5 = 8 none 1, 6 = 8 even 1, 7 = 8 odd 1. A frame is a 0 start bit, then data bits LSB first, then parity, then stop bits at 1. Even parity makes the count of ones over data plus parity even; odd parity makes it odd.
- R4: Control bits 6:5 set the transmit side. Code 2 drives rts_n high and every other code drives it low. Code 1 is the only code that enables the transmit interrupt. Code 3 holds txd at 0 (break) and starts no new character.
- R5: With reg_sel at 0, rdata is the status byte. Bit 0 is receive-full, bit 1 is transmit-holding-empty, bit 2 is the dcd_n level, bit 3 is the cts_n level, bit 4 is framing error, bit 5 is overrun, bit 6 is parity error and bit 7 is irq. With reg_sel at 1, rdata is the received byte.
- R6: A data write sets status bit 1 to 0 from the next clock on. The holding register moves into the shifter at the next bit boundary while the line is idle. A data write made while bit 1 is 0 is ignored and never transmitted.
- R7: A data read (rd_en with reg_sel at 1) clears receive-full, overrun, framing error and parity error. A 7-bit character reads back with bit 7 at 0.
- R8: When a character completes while receive-full is still set, overrun is set and the new character is discarded. The earlier byte stays readable.
- R9: If the first stop bit is sampled at 0, framing error is set. If the received parity bit does not match the selected parity, parity error is set. Both flags describe the byte in the holding register.
- R10: irq is 1 when bit 7 is set and receive-full or overrun is set. irq is also 1 when the transmit interrupt is enabled and the holding register is empty. Otherwise, and always in master reset, irq is 0.
- R11: At divide-by-16 and divide-by-64, a start bit counts only if the line is still low half a bit time after the falling edge. Each later bit is sampled one bit time after the previous sample. A low pulse shorter than half a bit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_en | input | 1 | Bit-clock enable, one pulse per external bit-clock period |
| reg_sel | input | 1 | 0 selects control/status, 1 selects data |
| wr_en | input | 1 | Host write strobe, one clock |
| rd_en | input | 1 | Host read strobe, one clock |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (status or received byte) |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rts_n | output | 1 | Active-low request-to-send |
| dcd_n | input | 1 | Active-low carrier-detect level |
| cts_n | input | 1 | Active-low clear-to-send level |
| irq | output | 1 | Interrupt flag |

## Verification
The hardest state to reach is the one where both transmit stages are full. The holding register empties on a bit boundary that the host cannot see. So the bench polls status bit 1 until the first byte has moved into the shifter, writes a second byte at once, and then writes a third that must be dropped. A receive overrun needs two complete frames with no read between them. Break and master reset are entered only after the transmit scoreboard has drained, so that no frame is cut short.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int BYTE_W   = 8;
  localparam int SLOW_DIV = 64;
  localparam int FAST_DIV = 16;
  localparam int DIV_W    = $clog2(SLOW_DIV) + 1;
  localparam int TAIL_W   = BYTE_W + 3;   // data + parity + two stops
  localparam int RXSH_W   = BYTE_W + 2;   // data + parity + one stop

  typedef struct packed {
    logic eight;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } fmt_t;

  function automatic fmt_t fmt_decode(input logic [2:0] code);
    fmt_t f;
    f.eight    = code[2];
    f.par_en   = (code != 3'd4) && (code != 3'd5);
    f.par_odd  = code[0];
    f.two_stop = (code == 3'd0) || (code == 3'd1) || (code == 3'd4);
    return f;
  endfunction

  function automatic logic [DIV_W-1:0] div_ratio(input logic [1:0] sel);
    case (sel)
      2'd0:    return DIV_W'(SLOW_DIV);
      2'd1:    return DIV_W'(FAST_DIV);
      default: return DIV_W'(1);
    endcase
  endfunction

  function automatic logic par_bit(input logic [BYTE_W-1:0] d, input logic eight,
                                   input logic odd);
    logic p;
    p = eight ? ^d : ^d[BYTE_W-2:0];
    return odd ? ~p : p;
  endfunction

  // bits following the start bit, first-out in bit 0, padded with mark
  function automatic logic [TAIL_W-1:0] frame_tail(input logic [BYTE_W-1:0] d,
                                                   input fmt_t f);
    logic [TAIL_W-1:0] v;
    v = '1;
    if (f.eight) begin
      v[BYTE_W-1:0] = d;
      if (f.par_en) v[BYTE_W] = par_bit(d, 1'b1, f.par_odd);
    end else begin
      v[BYTE_W-2:0] = d[BYTE_W-2:0];
      if (f.par_en) v[BYTE_W-1] = par_bit(d, 1'b0, f.par_odd);
    end
    return v;
  endfunction

  function automatic logic [3:0] tail_len(input fmt_t f);
    return 4'd7 + {3'b0, f.eight} + {3'b0, f.par_en} + (f.two_stop ? 4'd2 : 4'd1);
  endfunction
endpackage

// File: rtl/sa_tx.sv
module sa_tx
  import sa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mr,
  input  logic              tick,
  input  logic [DIV_W-1:0]  div,
  input  fmt_t              fmt,
  input  logic              brk,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wdata,
  output logic              tdre,
  output logic              line,
  output logic              tx_start
);
  logic [DIV_W-1:0]  cnt;
  logic [BYTE_W-1:0] thr;
  logic              thr_full;
  logic [TAIL_W-1:0] sreg;
  logic [3:0]        left;
  logic              bit_edge;

  assign bit_edge = tick && (cnt >= div - 1'b1);
  assign tx_start = bit_edge && (left == 4'd0) && thr_full && !brk;
  assign tdre     = !thr_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; thr <= '0; thr_full <= 1'b0; sreg <= '1; left <= '0; line <= 1'b1;
    end else if (mr) begin
      cnt <= '0; thr_full <= 1'b0; sreg <= '1; left <= '0; line <= 1'b1;
    end else begin
      if (tick) cnt <= bit_edge ? '0 : cnt + 1'b1;
      if (bit_edge) begin
        if (left != 4'd0) begin
          line <= sreg[0];
          sreg <= {1'b1, sreg[TAIL_W-1:1]};
          left <= left - 4'd1;
        end else if (tx_start) begin
          line <= 1'b0;
          sreg <= frame_tail(thr, fmt);
          left <= tail_len(fmt);
        end else begin
          line <= 1'b1;
        end
      end
      if (tx_start) thr_full <= 1'b0;
      else if (wr_stb && !thr_full) begin
        thr      <= wdata;
        thr_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sa_rx.sv
module sa_rx
  import sa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mr,
  input  logic              tick,
  input  logic [DIV_W-1:0]  div,
  input  logic              eight,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rxd,
  input  logic              rd_stb,
  output logic              rx_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rdrf,
  output logic              ovr,
  output logic              fe,
  output logic              pe
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_st_e;

  rx_st_e            st;
  logic [1:0]        sync;
  logic              rx_s;
  logic [DIV_W-1:0]  cnt;
  logic [DIV_W-1:0]  half;
  logic [3:0]        idx;
  logic [3:0]        rx_len;
  logic [RXSH_W-1:0] sh;
  logic [BYTE_W-1:0] got;
  logic              got_par;
  logic              bad_par;
  logic              bad_stop;

  assign rx_s    = sync[1];
  assign half    = div >> 1;
  assign rx_len  = 4'd8 + {3'b0, eight} + {3'b0, par_en};
  assign got     = eight ? sh[BYTE_W-1:0] : {1'b0, sh[BYTE_W-2:0]};
  assign got_par = eight ? sh[BYTE_W] : sh[BYTE_W-1];
  assign bad_par = par_en && (got_par != par_bit(got, eight, par_odd));
  assign bad_stop = !sh[rx_len - 4'd1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; cnt <= '0; idx <= '0; sh <= '0; rx_done <= 1'b0;
    end else if (mr) begin
      st <= RX_IDLE; cnt <= '0; idx <= '0; sh <= '0; rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: if (!rx_s) begin
            idx <= '0;
            if (div == DIV_W'(1)) begin
              st  <= RX_DATA;
              cnt <= '0;
            end else begin
              st  <= RX_START;
              cnt <= DIV_W'(1);
            end
          end
          RX_START: if (cnt >= half) begin
            if (!rx_s) begin
              st  <= RX_DATA;
              cnt <= '0;
            end else begin
              st <= RX_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          RX_DATA: if (cnt >= div - 1'b1) begin
            cnt     <= '0;
            sh[idx] <= rx_s;
            if (idx == rx_len - 4'd1) begin
              st      <= RX_IDLE;
              rx_done <= 1'b1;
            end else begin
              idx <= idx + 4'd1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0; rdrf <= 1'b0; ovr <= 1'b0; fe <= 1'b0; pe <= 1'b0;
    end else if (mr) begin
      rdrf <= 1'b0; ovr <= 1'b0; fe <= 1'b0; pe <= 1'b0;
    end else begin
      if (rd_stb) begin
        rdrf <= 1'b0; ovr <= 1'b0; fe <= 1'b0; pe <= 1'b0;
      end
      if (rx_done) begin
        if (rdrf && !rd_stb) begin
          ovr <= 1'b1;
        end else begin
          rx_byte <= got;
          rdrf    <= 1'b1;
          fe      <= bad_stop;
          pe      <= bad_par;
        end
      end
    end
  end
endmodule

// File: rtl/sa_top.sv
module sa_top
  import sa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk_en,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       rts_n,
  input  logic       dcd_n,
  input  logic       cts_n,
  output logic       irq
);
  logic [7:0]       ctrl;
  logic             mr;
  logic [DIV_W-1:0] div;
  fmt_t             fmt;
  logic [1:0]       tx_ctl;
  logic             rie, tie, brk;
  logic             tx_accept, rx_read;
  logic             tdre, tx_line, tx_start;
  logic             rx_done, rdrf, ovr, fe, pe;
  logic [7:0]       rx_byte;
  logic [7:0]       status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ctrl <= 8'h03;
    else if (wr_en && !reg_sel) ctrl <= wdata;
  end

  assign mr     = (ctrl[1:0] == 2'b11);
  assign div    = div_ratio(ctrl[1:0]);
  assign fmt    = fmt_decode(ctrl[4:2]);
  assign tx_ctl = ctrl[6:5];
  assign rie    = ctrl[7];
  assign tie    = (tx_ctl == 2'd1);
  assign brk    = (tx_ctl == 2'd3);
  assign rts_n  = (tx_ctl == 2'd2);

  assign tx_accept = wr_en && reg_sel && !mr && tdre;
  assign rx_read   = rd_en && reg_sel;

  sa_tx u_tx (
    .clk(clk), .rst_n(rst_n), .mr(mr), .tick(bclk_en), .div(div), .fmt(fmt),
    .brk(brk), .wr_stb(tx_accept), .wdata(wdata), .tdre(tdre), .line(tx_line),
    .tx_start(tx_start)
  );

  sa_rx u_rx (
    .clk(clk), .rst_n(rst_n), .mr(mr), .tick(bclk_en), .div(div),
    .eight(fmt.eight), .par_en(fmt.par_en), .par_odd(fmt.par_odd), .rxd(rxd),
    .rd_stb(rx_read), .rx_done(rx_done), .rx_byte(rx_byte), .rdrf(rdrf),
    .ovr(ovr), .fe(fe), .pe(pe)
  );

  assign txd    = mr ? 1'b1 : (brk ? 1'b0 : tx_line);
  assign irq    = !mr && ((rie && (rdrf || ovr)) || (tie && tdre));
  assign status = {irq, pe, ovr, fe, cts_n, dcd_n, tdre, rdrf};
  assign rdata  = reg_sel ? rx_byte : status;
endmodule

// File: rtl/sa_chk.sv
module sa_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mr,
  input logic       txd,
  input logic       irq,
  input logic       rie,
  input logic       brk,
  input logic       tdre,
  input logic       rdrf,
  input logic       ovr,
  input logic       tx_accept,
  input logic       tx_start,
  input logic       rx_read,
  input logic [7:0] rx_byte
);
  // R1
  mr_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mr |-> (txd && !irq));

  // R1
  mr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mr && $past(mr)) |-> (tdre && !rdrf && !ovr));

  // R4
  brk_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !mr) |-> !txd);

  // R4
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !tx_start);

  // R6
  tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> !tdre);

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_read |=> !ovr);

  // R8
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> (rdrf && $stable(rx_byte)));

  // R10
  irq_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mr && rie && rdrf) |-> irq);
endmodule

bind sa_top sa_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mr(mr), .txd(txd), .irq(irq), .rie(rie), .brk(brk),
  .tdre(tdre), .rdrf(rdrf), .ovr(ovr), .tx_accept(tx_accept), .tx_start(tx_start),
  .rx_read(rx_read), .rx_byte(rx_byte)
);

// File: tb/sa_top_bench.sv
module sa_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       txd, rts_n, irq;
  logic       rxd = 1'b1, dcd_n = 1'b1, cts_n = 1'b0;
  logic       bclk_en;
  int         cyc = 0;
  int         errs = 0, checks = 0;
  int         cur_div = 16, cur_fmt = 5;
  bit         mon_on = 1'b1;
  logic [7:0] txq[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign bclk_en = cyc[0];

  sa_top u_sa_top (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .reg_sel(reg_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd),
    .rts_n(rts_n), .dcd_n(dcd_n), .cts_n(cts_n), .irq(irq)
  );

  function automatic int dbits(int f); return (f < 4) ? 7 : 8; endfunction
  function automatic int pmode(int f); // 0 none, 1 even, 2 odd
    case (f) 0, 2, 6: return 1; 1, 3, 7: return 2; default: return 0; endcase
  endfunction
  function automatic int nstop(int f); return (f == 0 || f == 1 || f == 4) ? 2 : 1; endfunction
  function automatic logic want_par(logic [7:0] d, int f);
    logic ones;
    ones = ^((dbits(f) == 7) ? (d & 8'h7f) : d);
    return (pmode(f) == 2) ? ~ones : ones;
  endfunction
  function automatic logic [7:0] stx(bit rf, bit te, bit fe_b, bit ov, bit pe_b, bit iq);
    return {iq, pe_b, ov, fe_b, cts_n, dcd_n, te, rf};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_data(output logic [7:0] d);
    @(negedge clk); reg_sel = 1'b1; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(output logic [7:0] d);
    @(negedge clk); reg_sel = 1'b0; #1 d = rdata;
  endtask

  task automatic set_ctrl(input logic [7:0] c);
    wr(1'b0, c);
    cur_fmt = int'(c[4:2]);
    cur_div = (c[1:0] == 2'd0) ? 64 : ((c[1:0] == 2'd1) ? 16 : 1);
  endtask

  task automatic tx_push(input logic [7:0] d);
    wr(1'b1, d);
    txq.push_back((dbits(cur_fmt) == 7) ? (d & 8'h7f) : d);
  endtask

  task automatic wait_tdre();
    logic [7:0] s;
    peek(s);
    while (!s[1]) peek(s);
  endtask

  task automatic tx_drain();
    wait (txq.size() == 0);
    repeat (2 * cur_div + 6) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int bp;
    bp = 2 * cur_div;
    @(negedge clk); rxd = 1'b0; repeat (bp) @(negedge clk);
    for (int i = 0; i < dbits(cur_fmt); i++) begin rxd = d[i]; repeat (bp) @(negedge clk); end
    if (pmode(cur_fmt) != 0) begin
      rxd = want_par(d, cur_fmt) ^ bad_par; repeat (bp) @(negedge clk);
    end
    rxd = ~bad_stop; repeat (bp) @(negedge clk);
    rxd = 1'b1; repeat (bp + 8) @(negedge clk);
  endtask

  task automatic measure_start(input int exp_clk, input string req);
    int n;
    n = 0;
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    while (txd === 1'b0) begin n++; @(negedge clk); end
    chk(n == exp_clk, req, n, exp_clk);
  endtask

  // transmit monitor: decodes the line and pops the scoreboard
  initial begin : tx_mon
    logic [7:0] got, exp;
    bit bad;
    int bp;
    forever begin
      @(negedge clk);
      if (mon_on && rst_n && txd === 1'b0) begin
        bp = 2 * cur_div; got = '0; bad = 1'b0;
        repeat (cur_div) @(negedge clk);
        if (txd !== 1'b0) bad = 1'b1;
        for (int i = 0; i < dbits(cur_fmt); i++) begin
          repeat (bp) @(negedge clk); got[i] = txd;
        end
        if (pmode(cur_fmt) != 0) begin
          repeat (bp) @(negedge clk);
          if (txd !== want_par(got, cur_fmt)) bad = 1'b1;
        end
        for (int i = 0; i < nstop(cur_fmt); i++) begin
          repeat (bp) @(negedge clk);
          if (txd !== 1'b1) bad = 1'b1;
        end
        if (txq.size() == 0) chk(1'b0, "R6 unexpected tx frame", got, 0);
        else begin
          exp = txq.pop_front();
          chk(!bad && got == exp, "R3 tx frame", {bad, got}, exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] s, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    peek(s);
    chk(s == stx(0, 1, 0, 0, 0, 0), "R1 reset status", s, stx(0, 1, 0, 0, 0, 0));
    chk(txd === 1'b1 && irq === 1'b0, "R1 reset line/irq", {txd, irq}, 2'b10);

    // 8N1, divide by 16, rts low, no interrupts
    set_ctrl(8'h15);
    chk(rts_n === 1'b0, "R4 rts code0", rts_n, 0);
    tx_push(8'hFF);
    measure_start(32, "R2 div16 start bit clocks");
    tx_drain();

    // double buffering and ignored write
    tx_push(8'hA5);
    wait_tdre();
    tx_push(8'h3C);
    peek(s);
    chk(s[1] == 1'b0, "R6 holding full", s, 8'h00);
    wr(1'b1, 8'h99);
    tx_drain();
    chk(txq.size() == 0, "R6 scoreboard empty", txq.size(), 0);

    // other formats
    set_ctrl(8'h01); tx_push(8'hD5); tx_drain();   // 7 even 2
    set_ctrl(8'h0D); tx_push(8'h2B); tx_drain();   // 7 odd 1
    set_ctrl(8'h19); tx_push(8'h81); tx_drain();   // 8 even 1
    set_ctrl(8'h1D); tx_push(8'h7E); tx_drain();   // 8 odd 1
    set_ctrl(8'h10); tx_push(8'hFF);               // 8 none 2, divide by 64
    measure_start(128, "R2 div64 start bit clocks");
    tx_drain();
    set_ctrl(8'h06); tx_push(8'h7F);               // 7 odd 2, divide by 1
    measure_start(2, "R2 div1 start bit clocks");
    tx_drain();

    // receive, 8N1 /16
    set_ctrl(8'h15);
    rx_frame(8'h3C, 0, 0);
    peek(s);
    chk(s == stx(1, 1, 0, 0, 0, 0), "R5 rx full status", s, stx(1, 1, 0, 0, 0, 0));
    rd_data(d);
    chk(d == 8'h3C, "R7 rx data 8N1", d, 8'h3C);
    peek(s);
    chk(s[0] == 1'b0, "R7 read clears full", s, 8'h00);

    // 7-bit receive
    set_ctrl(8'h09);
    rx_frame(8'hDA, 0, 0);
    rd_data(d);
    chk(d == 8'h5A, "R7 7-bit read", d, 8'h5A);

    // parity error
    set_ctrl(8'h19);
    rx_frame(8'h66, 1, 0);
    peek(s);
    chk(s == stx(1, 1, 0, 0, 1, 0), "R9 parity error", s, stx(1, 1, 0, 0, 1, 0));
    rd_data(d);
    peek(s);
    chk(s[6] == 1'b0 && d == 8'h66, "R7 read clears parity err", {s, d}, 8'h66);

    // framing error
    set_ctrl(8'h15);
    rx_frame(8'h42, 0, 1);
    peek(s);
    chk(s[4] == 1'b1 && s[0] == 1'b1, "R9 framing error", s, 8'h13);
    rd_data(d);

    // overrun
    rx_frame(8'h11, 0, 0);
    rx_frame(8'h22, 0, 0);
    peek(s);
    chk(s == stx(1, 1, 0, 1, 0, 0), "R8 overrun status", s, stx(1, 1, 0, 1, 0, 0));
    rd_data(d);
    chk(d == 8'h11, "R8 first byte kept", d, 8'h11);
    peek(s);
    chk(s[5] == 1'b0 && s[0] == 1'b0, "R7 read clears overrun", s, 8'h02);

    // short low pulse is not a start bit
    @(negedge clk); rxd = 1'b0;
    repeat (6) @(negedge clk); rxd = 1'b1;
    repeat (80) @(negedge clk);
    peek(s);
    chk(s[0] == 1'b0, "R11 glitch rejected", s, 8'h02);

    // receive at divide by 1 and 64
    set_ctrl(8'h1E);
    rx_frame(8'hC3, 0, 0);
    rd_data(d); peek(s);
    chk(d == 8'hC3 && s[6] == 1'b0, "R2 div1 rx", d, 8'hC3);
    set_ctrl(8'h14);
    rx_frame(8'h5E, 0, 0);
    rd_data(d);
    chk(d == 8'h5E, "R11 div64 rx", d, 8'h5E);

    // line level bits
    dcd_n = 1'b0; cts_n = 1'b1;
    peek(s);
    chk(s[3:2] == 2'b10, "R5 modem levels", s[3:2], 2'b10);

    // interrupts and rts
    set_ctrl(8'h35);
    @(negedge clk);
    chk(irq === 1'b1 && rts_n === 1'b0, "R10 tx irq when empty", {irq, rts_n}, 2'b10);
    set_ctrl(8'h55);
    @(negedge clk);
    chk(rts_n === 1'b1 && irq === 1'b0, "R4 rts high code2", {rts_n, irq}, 2'b10);
    set_ctrl(8'h95);
    @(negedge clk);
    chk(irq === 1'b0, "R10 idle no irq", irq, 0);
    rx_frame(8'h77, 0, 0);
    chk(irq === 1'b1, "R10 rx irq", irq, 1);
    rd_data(d);
    @(negedge clk);
    chk(irq === 1'b0, "R10 irq drops after read", irq, 0);

    // break
    mon_on = 1'b0;
    set_ctrl(8'h75);
    wr(1'b1, 8'h00);
    repeat (200) @(negedge clk);
    chk(txd === 1'b0, "R4 break holds space", txd, 0);
    set_ctrl(8'h03);
    @(negedge clk);
    chk(txd === 1'b1, "R1 master reset line mark", txd, 1);
    set_ctrl(8'h15);
    repeat (200) @(negedge clk);
    chk(txd === 1'b1, "R4 break write not sent", txd, 1);
    mon_on = 1'b1;

    // master reset drops received byte and masks irq
    rx_frame(8'h12, 0, 0);
    set_ctrl(8'hA3);
    @(negedge clk);
    peek(s);
    chk(s == stx(0, 1, 0, 0, 0, 0), "R1 master reset status", s, stx(0, 1, 0, 0, 0, 0));
    chk(irq === 1'b0, "R1 master reset irq", irq, 0);

    chk(txq.size() == 0, "R3 all frames seen", txq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule